// File: doc/BRIEF.md
# Word Add/Subtract Unit with Flags

This block is one execute stage for integer add and subtract operations in a core whose general registers are 64 bits wide but whose software treats every value as a 32-bit word. Each operand contributes only its low word. The 32-bit outcome goes back zero-extended to register width. Carry, signed overflow and the condition-field sign are all taken from word bit 31.

The stage accepts one operation per cycle, marked by `in_valid`. It takes two register values, the current carry, overflow and summary-overflow flags, a 3-bit operation code, and the overflow-enable and record bits. One clock later it returns the destination value, the three updated flags, and a 4-bit condition field with its write strobe. All six operations map onto a single shared adder. The operation code only chooses the two adder terms and the carry-in.

Top module: `wsu_word_addsub`

## Requirements
- R1: `result` holds the 32-bit outcome in bits 31:0 and zero in bits 63:32. Bits 63:32 of `src_a` and `src_b` have no effect on any output.
- R2: Operation code 0 (plain add) gives A+B modulo 2^32 and passes `ca_in` through to `ca_out` unchanged.
- R3: Operation code 1 (add with carry-out) gives A+B. `ca_out` is 1 exactly when the result is unsigned-below A.
- R4: Operation code 2 (add-extended) gives A+B+`ca_in`. `ca_out` is 1 when the result is unsigned-below A, or when `ca_in` is 1 and the result equals A.
- R5: Operation code 3 (add carry to A) gives A+`ca_in`. `ca_out` is 1 exactly when the result is unsigned-below A.
- R6: Operation code 4 (add carry minus one) gives A+`ca_in`−1. `ca_out` is 1 exactly when A is nonzero or `ca_in` is 1.
- R7: Operation code 5 (subtract-from) gives B−A, with B as the minuend, and passes `ca_in` through unchanged.
- R8: With `oe`=1, `ov_out` is 1 exactly when the exact signed value of the operation, computed on the sign-extended words, differs from the 32-bit result read as signed. For example, 0x7FFFFFFF+1 gives 0x80000000 with `ov_out`=1.
- R9: With `oe`=1, `so_out` is `so_in` OR the new overflow, so a set summary flag never clears.
- R10: With `oe`=0, `ov_out` equals `ov_in` and `so_out` equals `so_in`.
- R11: With `rc`=1, `cr0_wr` is 1 and `cr0` is {LT, GT, EQ, SO} in bits 3..0. LT, GT and EQ classify the 32-bit result as signed, and SO copies the updated `so_out`. With `rc`=0, `cr0_wr` and `cr0` are 0.
- R12: Operation codes 6 and 7 behave exactly as code 0.
- R13: Reset clears every output. Outputs appear one clock after an accepted operation, `out_valid` follows `in_valid` by one clock, and the data outputs hold while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 3 | Operation code (see R2–R7, R12) |
| src_a | input | 64 | First register operand (A) |
| src_b | input | 64 | Second register operand (B) |
| ca_in | input | 1 | Current carry flag |
| ov_in | input | 1 | Current overflow flag |
| so_in | input | 1 | Current summary-overflow flag |
| oe | input | 1 | Overflow-enable bit |
| rc | input | 1 | Record bit: update the condition field |
| out_valid | output | 1 | Registered results are for a new operation |
| result | output | 64 | Zero-extended destination value |
| ca_out | output | 1 | Updated carry flag |
| ov_out | output | 1 | Updated overflow flag |
| so_out | output | 1 | Updated summary-overflow flag |
| cr0_wr | output | 1 | Condition field is to be written |
| cr0 | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The assertions take for granted that the flag inputs and control bits are known, 0 or 1, in every cycle where `in_valid` is high. Their `$past` terms assume that the inputs of the previous cycle are the ones the register captured. The stimulus therefore drives every input on the falling edge and keeps it constant through the following rising edge.

Operands mix 32-bit boundary words (0, 1, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF) with random words. The upper halves are always filled with unrelated random bits, so any leak from bits 63:32 shows up in the result or the flags. All flag inputs, `oe`, `rc` and the two reserved operation codes are also randomised.

// File: rtl/wsu_pkg.sv
package wsu_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_ADDC  = 3'd1,
        OP_ADDE  = 3'd2,
        OP_ADDZE = 3'd3,
        OP_ADDME = 3'd4,
        OP_SUBF  = 3'd5
    } wsu_op_e;

    localparam int CR_LT = 3;
    localparam int CR_GT = 2;
    localparam int CR_EQ = 1;
    localparam int CR_SO = 0;

endpackage

// File: rtl/wsu_opsel.sv
module wsu_opsel
    import wsu_pkg::*;
#(
    parameter int WLEN = 32,
    parameter int OPW  = 3
) (
    input  logic [OPW-1:0]  op,
    input  logic [WLEN-1:0] a_w,
    input  logic [WLEN-1:0] b_w,
    input  logic            ca_in,
    output logic [WLEN-1:0] term_x,
    output logic [WLEN-1:0] term_y,
    output logic            carry_in,
    output logic            ca_writes
);
    // Every operation is expressed as term_x + term_y + carry_in.
    always_comb begin
        term_x    = a_w;
        term_y    = b_w;
        carry_in  = 1'b0;
        ca_writes = 1'b0;
        case (op)
            OP_ADDC: begin
                ca_writes = 1'b1;
            end
            OP_ADDE: begin
                carry_in  = ca_in;
                ca_writes = 1'b1;
            end
            OP_ADDZE: begin
                term_y    = '0;
                carry_in  = ca_in;
                ca_writes = 1'b1;
            end
            OP_ADDME: begin
                term_y    = '1;
                carry_in  = ca_in;
                ca_writes = 1'b1;
            end
            OP_SUBF: begin
                // B - A == ~A + B + 1
                term_x   = ~a_w;
                carry_in = 1'b1;
            end
            default: begin
                // plain add and the reserved codes
            end
        endcase
    end
endmodule

// File: rtl/wsu_adder.sv
module wsu_adder #(
    parameter int WLEN = 32
) (
    input  logic [WLEN-1:0] x,
    input  logic [WLEN-1:0] y,
    input  logic            cin,
    output logic [WLEN-1:0] sum,
    output logic            cout,
    output logic            ovf
);
    localparam int EXW = WLEN + 2;

    logic [WLEN:0]         wide_sum;
    logic signed [EXW-1:0] exact_sum;
    logic signed [EXW-1:0] sext_sum;

    always_comb begin
        wide_sum  = {1'b0, x} + {1'b0, y} + {{WLEN{1'b0}}, cin};
        sum       = wide_sum[WLEN-1:0];
        cout      = wide_sum[WLEN];
        exact_sum = $signed({{2{x[WLEN-1]}}, x}) + $signed({{2{y[WLEN-1]}}, y})
                  + $signed({{(EXW-1){1'b0}}, cin});
        sext_sum  = $signed({{2{sum[WLEN-1]}}, sum});
        ovf       = (exact_sum != sext_sum);
    end
endmodule

// File: rtl/wsu_crgen.sv
module wsu_crgen
    import wsu_pkg::*;
#(
    parameter int WLEN = 32
) (
    input  logic [WLEN-1:0] value,
    input  logic            so_now,
    input  logic            enable,
    output logic [3:0]      cr_field
);
    logic is_zero;
    logic is_neg;

    always_comb begin
        is_zero  = (value == '0);
        is_neg   = value[WLEN-1];
        cr_field = '0;
        if (enable) begin
            cr_field[CR_LT] = is_neg;
            cr_field[CR_GT] = !is_neg && !is_zero;
            cr_field[CR_EQ] = is_zero;
            cr_field[CR_SO] = so_now;
        end
    end
endmodule

// File: rtl/wsu_word_addsub.sv
module wsu_word_addsub
    import wsu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32,
    parameter int OPW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OPW-1:0]  op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic            ca_in,
    input  logic            ov_in,
    input  logic            so_in,
    input  logic            oe,
    input  logic            rc,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            ca_out,
    output logic            ov_out,
    output logic            so_out,
    output logic            cr0_wr,
    output logic [3:0]      cr0
);
    localparam int HIW = XLEN - WLEN;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
        logic            ca;
        logic            ov;
        logic            so;
        logic            crw;
        logic [3:0]      cr;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [WLEN-1:0] a_w, b_w, tx, ty, sum_w;
    logic            cin, ca_writes, cout, ovf, so_new;
    logic [3:0]      cr_new;

    assign a_w = src_a[WLEN-1:0];
    assign b_w = src_b[WLEN-1:0];

    wsu_opsel #(.WLEN(WLEN), .OPW(OPW)) u_opsel (
        .op(op), .a_w(a_w), .b_w(b_w), .ca_in(ca_in),
        .term_x(tx), .term_y(ty), .carry_in(cin), .ca_writes(ca_writes)
    );

    wsu_adder #(.WLEN(WLEN)) u_adder (
        .x(tx), .y(ty), .cin(cin), .sum(sum_w), .cout(cout), .ovf(ovf)
    );

    assign so_new = oe ? (so_in | ovf) : so_in;

    wsu_crgen #(.WLEN(WLEN)) u_crgen (
        .value(sum_w), .so_now(so_new), .enable(rc), .cr_field(cr_new)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.res = {{HIW{1'b0}}, sum_w};
            stage_d.ca  = ca_writes ? cout : ca_in;
            stage_d.ov  = oe ? ovf : ov_in;
            stage_d.so  = so_new;
            stage_d.crw = rc;
            stage_d.cr  = cr_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid = stage_q.vld;
    assign result    = stage_q.res;
    assign ca_out    = stage_q.ca;
    assign ov_out    = stage_q.ov;
    assign so_out    = stage_q.so;
    assign cr0_wr    = stage_q.crw;
    assign cr0       = stage_q.cr;

    a_r1_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (result[XLEN-1:WLEN] == '0));

    a_r9_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(so_in)) |-> so_out);

    a_r10_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(oe)) |-> (ov_out == $past(ov_in) && so_out == $past(so_in)));

    a_r11_cr_so_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cr0_wr) |-> (cr0[CR_SO] == so_out));

    a_r11_cr_class: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_wr |-> ($countones(cr0[3:1]) == 1));

    a_r7_ca_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(op) == OP_ADD || $past(op) == OP_SUBF)) |-> (ca_out == $past(ca_in)));

    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(in_valid) && $past(rst_n)) |-> ($stable(result) && $stable(cr0)));

endmodule

// File: tb/test_wsu_word_addsub.sv
module test_wsu_word_addsub;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [63:0] src_a = '0, src_b = '0;
    logic        ca_in = 0, ov_in = 0, so_in = 0, oe = 0, rc = 0;
    logic        out_valid, ca_out, ov_out, so_out, cr0_wr;
    logic [63:0] result;
    logic [3:0]  cr0;

    int errors = 0;
    int checks = 0;

    logic        e_vld = 0;
    logic [63:0] e_res = '0;
    logic        e_ca = 0, e_ov = 0, e_so = 0, e_crw = 0;
    logic [3:0]  e_cr = '0;
    string       e_tag = "R13";

    always #5 clk = ~clk;

    wsu_word_addsub i_wsu_word_addsub (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .ca_in(ca_in), .ov_in(ov_in), .so_in(so_in),
        .oe(oe), .rc(rc), .out_valid(out_valid), .result(result), .ca_out(ca_out),
        .ov_out(ov_out), .so_out(so_out), .cr0_wr(cr0_wr), .cr0(cr0)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R13 out_valid", {63'b0, out_valid}, {63'b0, e_vld});
        chk({e_tag, " result"}, result, e_res);
        chk({e_tag, " ca"}, {63'b0, ca_out}, {63'b0, e_ca});
        chk("R8/R10 ov", {63'b0, ov_out}, {63'b0, e_ov});
        chk("R9/R10 so", {63'b0, so_out}, {63'b0, e_so});
        chk("R11 cr0_wr", {63'b0, cr0_wr}, {63'b0, e_crw});
        chk("R11 cr0", {60'b0, cr0}, {60'b0, e_cr});
    endtask

    // Behavioural reference taken from the requirement text.
    task automatic model(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                         input logic ci, input logic vi, input logic si, input logic oen,
                         input logic rcn);
        longint ua, ub, sa, sb, exact, r;
        logic [31:0] rw;
        logic nca, nov, nso;
        ua = longint'(a[31:0]);
        ub = longint'(b[31:0]);
        sa = longint'($signed(a[31:0]));
        sb = longint'($signed(b[31:0]));
        nca = ci;
        case (o)
            3'd1: begin r = ua + ub; exact = sa + sb; e_tag = "R3"; end
            3'd2: begin r = ua + ub + longint'(ci); exact = sa + sb + longint'(ci); e_tag = "R4"; end
            3'd3: begin r = ua + longint'(ci); exact = sa + longint'(ci); e_tag = "R5"; end
            3'd4: begin r = ua + longint'(ci) - 1; exact = sa + longint'(ci) - 1; e_tag = "R6"; end
            3'd5: begin r = ub - ua; exact = sb - sa; e_tag = "R7"; end
            3'd0: begin r = ua + ub; exact = sa + sb; e_tag = "R2"; end
            default: begin r = ua + ub; exact = sa + sb; e_tag = "R12"; end
        endcase
        rw = r[31:0];
        case (o)
            3'd1: nca = (rw < a[31:0]);
            3'd2: nca = (rw < a[31:0]) || (ci && rw == a[31:0]);
            3'd3: nca = (rw < a[31:0]);
            3'd4: nca = (a[31:0] != 0) || ci;
            default: nca = ci;
        endcase
        nov = vi;
        nso = si;
        if (oen) begin
            nov = (exact != longint'($signed(rw)));
            nso = si | nov;
        end
        e_res = {32'b0, rw};
        e_ca  = nca;
        e_ov  = nov;
        e_so  = nso;
        e_crw = rcn;
        e_cr  = rcn ? {$signed(rw) < 0, $signed(rw) > 0, rw == 0, nso} : 4'b0;
    endtask

    // One cycle: compare what the previous edge produced, then drive new inputs.
    task automatic step(input logic v, input logic [2:0] o, input logic [63:0] a,
                        input logic [63:0] b, input logic ci, input logic vi, input logic si,
                        input logic oen, input logic rcn);
        @(negedge clk);
        compare();
        in_valid = v; op = o; src_a = a; src_b = b;
        ca_in = ci; ov_in = vi; so_in = si; oe = oen; rc = rcn;
        e_vld = v;
        if (v) model(o, a, b, ci, vi, si, oen, rcn);
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 7))
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(); // R13 reset state: all zero
        rst_n = 1'b1;
        // R8 R9: 0x7FFFFFFF + 1 -> 0x80000000, OV and SO set
        step(1, 3'd0, 64'h0000_0000_7FFF_FFFF, 64'h1, 0, 0, 0, 1, 1);
        // R11: 0xFFFFFFFF classifies LT; R1 upper operand bits ignored
        step(1, 3'd0, 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_0000_0000, 0, 0, 0, 0, 1);
        // R3: carry out of 0xFFFFFFFF + 1
        step(1, 3'd1, 64'hFFFF_FFFF, 64'h1, 0, 0, 0, 0, 1);
        // R4: result equals A with carry in
        step(1, 3'd2, 64'h5, 64'hFFFF_FFFF, 1, 0, 0, 0, 1);
        // R5: A = 0xFFFFFFFF plus carry wraps
        step(1, 3'd3, 64'hFFFF_FFFF, 64'h0, 1, 0, 0, 1, 1);
        // R6: A = 0 and no carry -> 0xFFFFFFFF, CA clear
        step(1, 3'd4, 64'h0, 64'h0, 0, 0, 0, 1, 1);
        // R6: A nonzero -> CA set
        step(1, 3'd4, 64'h7, 64'h0, 0, 0, 0, 1, 1);
        // R7: B - A, minuend B, CA passed through
        step(1, 3'd5, 64'hA, 64'h5, 1, 0, 0, 1, 1);
        // R7 R8: INT_MIN - 1 overflows
        step(1, 3'd5, 64'h1, 64'h8000_0000, 0, 0, 0, 1, 1);
        // R10: overflow disabled keeps flags
        step(1, 3'd0, 64'h7FFF_FFFF, 64'h1, 0, 1, 0, 0, 0);
        // R9: sticky SO with no new overflow
        step(1, 3'd0, 64'h1, 64'h1, 0, 0, 1, 1, 1);
        // R12: reserved codes act as add
        step(1, 3'd6, 64'h3, 64'h4, 1, 0, 0, 0, 1);
        step(1, 3'd7, 64'hFFFF_FFFF, 64'h1, 0, 0, 0, 1, 1);
        // R13: hold while idle
        step(0, 3'd1, 64'h55, 64'h66, 1, 1, 1, 1, 0);
        step(0, 3'd2, 64'h77, 64'h88, 0, 0, 0, 0, 1);
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 9) != 0, 3'($urandom_range(0, 7)),
                 {32'($urandom), pick()}, {32'($urandom), pick()},
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        step(0, 3'd0, 64'h0, 64'h0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule